// File: doc/BRIEF.md
# Four-Mode Built-In Logic Block Observer

This block is an n-bit register that sits between two pieces of logic. It can work as an ordinary storage register, a serial scan chain, a free-running pseudo-random pattern source, or a signature compactor. Two mode pins choose the behaviour on every clock, so a test controller can change the role of the register between test phases without changing any wiring around it.

The register holds bits q[0] (head) to q[WIDTH-1] (tail). The two shifting modes and the compactor move each bit one place toward the tail on every clock. The bit that enters the head is the scan input in scan mode, and the feedback bit in the other two. The feedback bit is the XOR of every state bit whose position is set in the `TAPS` parameter. The tail bit is always available on the scan output. The parallel output always shows the whole register.

The parallel data path has no valid/ready handshake. The register samples its input on every clock, so it never applies back-pressure. A caller that wants to hold the value stops it by choosing a mode, not by stalling the interface.

Top module: `bilbo_reg`

## Requirements
- R1: While the active-low reset is held low, every register bit is 0, and it stays 0 until the first clock edge after release.
- R2: With {mode_hi, mode_lo} = 00 (scan), on each clock q[0] takes scan_in and q[i] takes q[i-1] for i >= 1.
- R3: With mode 01 (pattern generation), on each clock q[0] takes the XOR of the q[i] whose bit i is set in TAPS, and q[i] takes q[i-1] for i >= 1. The parallel data input has no effect in this mode.
- R4: With mode 10 (functional), on each clock the register loads the parallel data input unchanged.
- R5: With mode 11 (compaction), on each clock q[0] takes the feedback bit XOR par_in[0], and q[i] takes q[i-1] XOR par_in[i] for i >= 1.
- R6: scan_out equals q[WIDTH-1] in every mode.
- R7: par_out equals the full register q in every mode, with bit i of par_out being q[i].
- R8: With a maximal-length tap set and a nonzero seed, pattern generation visits 2^WIDTH - 1 distinct states. It returns to the seed after exactly that many clocks and never reaches all zeros.
- R9: In pattern-generation mode an all-zero register stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register |
| mode_hi | input | 1 | Upper mode select bit |
| mode_lo | input | 1 | Lower mode select bit |
| par_in | input | WIDTH | Parallel data from upstream logic |
| par_out | output | WIDTH | Parallel register contents to downstream logic |
| scan_in | input | 1 | Serial input into the head bit |
| scan_out | output | 1 | Serial output from the tail bit |

## Verification
The bench builds two copies of the block. The first uses the default eight bits with taps 0xB8, so it covers shifting, loading, pattern generation and signature compaction across a full byte against a reference model. The second uses five bits with taps 0x14. That short maximal sequence lets the bench walk the entire 31-state cycle, confirm that it returns to its seed and never passes through zero, and do so well within the run length.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_PRPG = 2'b01,
    MODE_LOAD = 2'b10,
    MODE_MISR = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH-1:0] tapped;

  // Each bit takes part in the parity only if its tap is set.
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = state[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign fb = ^tapped;
endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  bilbo_mode_e      mode,
  input  logic [WIDTH-2:0] state_lo,
  input  logic [WIDTH-1:0] pin,
  input  logic             si,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  logic             lead;
  logic [WIDTH-1:0] chain;

  // Head bit: serial input in scan mode, feedback otherwise.
  always_comb lead = (mode == MODE_SCAN) ? si : fb;
  assign chain = {state_lo, lead};

  always_comb begin
    unique case (mode)
      MODE_SCAN, MODE_PRPG: nxt = chain;
      MODE_LOAD:            nxt = pin;
      MODE_MISR:            nxt = chain ^ pin;
      default:              nxt = chain;
    endcase
  end
endmodule

// File: rtl/bilbo_state.sv
module bilbo_state #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_hi,
  input  logic             mode_lo,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  input  logic             scan_in,
  output logic             scan_out
);
  localparam int unsigned TAIL = WIDTH - 1;

  bilbo_mode_e      mode;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;
  logic             fb;

  assign mode = bilbo_mode_e'({mode_hi, mode_lo});

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state (q),
    .fb    (fb)
  );

  bilbo_next #(.WIDTH(WIDTH)) u_next (
    .mode     (mode),
    .state_lo (q[WIDTH-2:0]),
    .pin      (par_in),
    .si       (scan_in),
    .fb       (fb),
    .nxt      (q_nxt)
  );

  bilbo_state #(.WIDTH(WIDTH)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (q_nxt),
    .q     (q)
  );

  assign par_out  = q;
  assign scan_out = q[TAIL];

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SCAN) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)})); // R2

  AST_PRPG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PRPG) |=> (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0]))); // R3

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (par_out == $past(par_in))); // R4

  AST_MISR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MISR) |=> (par_out[WIDTH-1:1] == ($past(par_out[WIDTH-2:0]) ^ $past(par_in[WIDTH-1:1])))); // R5

  AST_SCAN_OUT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SCAN) |=> (scan_out == $past(par_out[WIDTH-2]))); // R6

  AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PRPG && par_out == '0) |=> (par_out == '0)); // R9
endmodule

// File: tb/tb_bilbo_reg.sv
module tb_bilbo_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_hi = 1'b1, mode_lo = 1'b0;
  logic [7:0] par_in = '0;
  logic [7:0] par_out;
  logic       scan_in = 1'b0;
  logic       scan_out;
  logic [4:0] par_out_s;
  logic       scan_out_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bilbo_reg dut (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .par_in(par_in), .par_out(par_out), .scan_in(scan_in), .scan_out(scan_out)
  );

  bilbo_reg #(.WIDTH(5), .TAPS(5'h14)) dut_small (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .par_in(par_in[4:0]), .par_out(par_out_s), .scan_in(scan_in), .scan_out(scan_out_s)
  );

  function automatic logic [7:0] ref_next(input logic [1:0] m, input logic [7:0] q,
      input logic [7:0] d, input logic si, input logic [7:0] taps, input int w);
    logic [7:0] mask, chain;
    logic fbit, lead;
    mask  = 8'((9'd1 << w) - 9'd1);
    fbit  = ^(q & taps);
    lead  = (m == 2'b00) ? si : fbit;
    chain = ((q << 1) | {7'd0, lead}) & mask;
    case (m)
      2'b10:   ref_next = d & mask;
      2'b11:   ref_next = (chain ^ d) & mask;
      default: ref_next = chain;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    {mode_hi, mode_lo} = m;
  endtask

  task automatic t_reset();
    check("R1 reset value", par_out, 8'h00);
    check("R6 scan_out in reset", {7'd0, scan_out}, 8'h00);
    rst_n = 1'b1;
    #3;
    check("R1 held after release", par_out, 8'h00);
  endtask

  task automatic t_scan();
    logic [7:0] model = par_out;
    logic [7:0] pat = 8'b1011_0010;
    set_mode(2'b00);
    for (int i = 0; i < 8; i++) begin
      scan_in = pat[7-i];
      model = ref_next(2'b00, model, par_in, scan_in, 8'hB8, 8);
      tick();
      check("R2 scan shift", par_out, model);
      check("R6 scan_out tail", {7'd0, scan_out}, {7'd0, model[7]});
    end
    check("R7 scanned word", par_out, pat);
  endtask

  task automatic t_load();
    logic [7:0] vals [4] = '{8'h5A, 8'hFF, 8'h80, 8'h01};
    set_mode(2'b10);
    foreach (vals[k]) begin
      par_in = vals[k];
      tick();
      check("R4 parallel load", par_out, vals[k]);
      check("R6 scan_out after load", {7'd0, scan_out}, {7'd0, vals[k][7]});
    end
  endtask

  task automatic t_prpg();
    logic [7:0] model;
    set_mode(2'b10);
    par_in = 8'h01;
    tick();
    model = 8'h01;
    set_mode(2'b01);
    for (int i = 0; i < 20; i++) begin
      par_in = 8'(i * 37 + 11);
      model = ref_next(2'b01, model, 8'h00, 1'b0, 8'hB8, 8);
      tick();
      check("R3 pattern step, par_in ignored", par_out, model);
      check("R6 scan_out in generator", {7'd0, scan_out}, {7'd0, model[7]});
    end
  endtask

  task automatic t_lockup();
    set_mode(2'b10);
    par_in = 8'h00;
    tick();
    set_mode(2'b01);
    for (int i = 0; i < 5; i++) begin
      par_in = 8'hA5;
      tick();
      check("R9 zero state holds", par_out, 8'h00);
    end
  endtask

  task automatic t_misr(input logic [7:0] seed, input logic [7:0] salt);
    logic [7:0] model;
    set_mode(2'b10);
    par_in = seed;
    tick();
    model = seed;
    set_mode(2'b11);
    for (int i = 0; i < 16; i++) begin
      par_in = 8'(i * 29) ^ salt;
      model = ref_next(2'b11, model, par_in, 1'b0, 8'hB8, 8);
      tick();
      check("R5 compaction step", par_out, model);
    end
    check("R5 final signature", par_out, model);
  endtask

  task automatic t_period();
    logic [4:0] seed = 5'b00001;
    bit early = 0, zero = 0;
    set_mode(2'b10);
    par_in = {3'd0, seed};
    tick();
    set_mode(2'b01);
    for (int i = 1; i <= 31; i++) begin
      tick();
      if (par_out_s == 5'd0) zero = 1;
      if (i < 31 && par_out_s == seed) early = 1;
    end
    check("R8 returns to seed after 31", {3'd0, par_out_s}, {3'd0, seed});
    check("R8 no early repeat", {7'd0, early}, 8'h00);
    check("R8 never zero", {7'd0, zero}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_scan();
    t_load();
    t_prpg();
    t_lockup();
    t_misr(8'h00, 8'h3C);
    t_misr(8'hC3, 8'h81);
    t_period();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule